// File: doc/BRIEF.md
# Register-Write Command Stream Interpreter

This block sits between a command fetcher and a register bus. It accepts a stream of 32-bit command words on a valid/ready input, decodes each one-word header, gathers the words that follow it, and issues register writes, read-modify-write sequences and lookup-table bus transfers. A block-select bitmap, loaded by a special write to a fixed select address, stays in force for all later register writes and is presented to the register fabric alongside every transaction.

Words are consumed one per cycle. The only stall is the read half of a masked modify: the input is held off until the register fabric returns the old value. Command ordering is enforced: register and table commands are refused until a block-select command has been seen, every table burst must be closed by three no-op words, and any malformed header or illegal order sets a sticky error. From then on, every word is accepted and dropped until reset.

Top module: `regcmd_interp`

## Requirements
- R1: After reset `cmd_ready` is 1, `err` is 0, `bus_wr`, `bus_rd` and `lut_wr` are 0 and `blk_sel` is 0.
- R2: A header whose bits 31:28 equal 0x0 is a no-op. It consumes one word and produces no bus activity and no error.
- R3: A single write (opcode 0x1) with header bit 27 set and offset bits 19:0 equal to parameter `SEL_OFS` (default 0xAC060) is a block-select command. Its data word, ANDed with 0x80FE01FF, becomes `blk_sel` one cycle after acceptance, and no bus write is issued.
- R4: Any command with opcode 0x1 to 0x6, other than a block-select, that arrives before the first block-select sets `err`.
- R5: A single write (opcode 0x1) takes two words. One cycle after the value word is accepted, `bus_wr` pulses for one cycle with `bus_addr` = header bits 19:0, `bus_abs` = header bit 27 and `bus_wdata` = the value. Every issued address has bits 1:0 equal to 0.
- R6: A masked modify (opcode 0x2) takes the header, a mask word and a value word. It then pulses `bus_rd` to the header offset and holds `cmd_ready` low. In the cycle after `bus_rvalid`, it writes (rdata & ~mask) | (value & mask) to the same address.
- R7: An indexed block write (opcode 0x3) reads a dword count from bits 13:0 of its second word. It then writes that many data words, all to the header offset.
- R8: An auto-increment block write (opcode 0x4) uses the same count field and writes data words to the header offset plus 4 for each successive word.
- R9: A wrapping block write (opcode 0x5) takes the wrap size from bits 19:16 of its second word and the count from bits 13:0. With bit 31 clear, the address advances by 4 and returns to the start offset after every wrap-size words. With bit 31 set, the address does not move. A wrap size below 2 sets `err`.
- R10: A table write (opcode 0x6) takes `lut_table` from header bit 16, `lut_block` from header bits 15:0, `lut_xfer` from bits 23:16 of the second word and a length from bits 13:0. Each of the length data words then pulses `lut_wr` with that word on `lut_wdata`.
- R11: The three words after a table burst must each have bits 31:28 equal to 0. Any other word there sets `err`.
- R12: A header with opcode 0x7 to 0xF, or a register-command header (opcodes 0x1 to 0x5) with bits 1:0 non-zero, sets `err`. `err` stays set until reset. While it is set, words are accepted and no `bus_wr`, `bus_rd` or `lut_wr` is issued.
- R13: A block write with a count of 0 consumes only its two words, writes nothing and returns to header decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Word accepted when high with valid |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 20 | Register byte offset |
| bus_abs | output | 1 | Offset is global rather than relative to selected blocks |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data |
| bus_rvalid | input | 1 | Read data valid |
| blk_sel | output | 32 | Current block-select bitmap |
| lut_wr | output | 1 | Table bus write strobe |
| lut_table | output | 1 | Table select |
| lut_block | output | 16 | Table block select |
| lut_xfer | output | 8 | Table transfer size |
| lut_wdata | output | 32 | Table data word |
| err | output | 1 | Sticky sequence/format error |

## Verification
Assertions check these properties on every cycle:
- The three strobes are mutually exclusive.
- The error flag is sticky and silences all strobes.
- Input is stalled while a modify read is outstanding.
- No register write goes out before the first block-select.
- Issued addresses stay word aligned.
- The wrap counter stays below the wrap size, and the address returns to the start when it wraps.
- The select bitmap changes only on a load.

The bench scenarios are the only place where the following are shown:
- The actual address sequences of the three block modes.
- The merged modify value.
- The bitmap masking.
- Padding enforcement after a table burst.
- Each individual path that raises the error.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 20;
  localparam int unsigned CNT_W  = 14;
  localparam int unsigned WSZ_W  = 4;
  localparam int unsigned PAD_WORDS = 3;
  localparam logic [WORD_W-1:0] SEL_VALID_MASK = 32'h80FE_01FF;
  localparam logic [WSZ_W-1:0]  WRAP_MIN = 4'd2;

  typedef enum logic [3:0] {
    OP_NOP     = 4'h0,
    OP_SINGLE  = 4'h1,
    OP_MODIFY  = 4'h2,
    OP_INDEX   = 4'h3,
    OP_AUTOINC = 4'h4,
    OP_WRAP    = 4'h5,
    OP_LUT     = 4'h6
  } op_e;

  typedef enum logic [2:0] {
    ST_HDR, ST_ARG, ST_VAL, ST_RD, ST_DATA, ST_LUT, ST_PAD, ST_ERR
  } state_e;

  typedef struct packed {
    op_e              op;
    logic             known;
    logic             is_reg;
    logic             misaligned;
    logic             is_sel;
    logic             absolute;
    logic [OFS_W-1:0] ofs;
  } hdr_t;

endpackage

// File: rtl/regcmd_hdr_decode.sv
module regcmd_hdr_decode
  import regcmd_pkg::*;
#(
  parameter logic [OFS_W-1:0] SEL_OFS = 20'hAC060
) (
  input  logic [WORD_W-1:0] word,
  output hdr_t              dec
);

  logic [3:0] opf;

  always_comb begin
    opf            = word[31:28];
    dec.op         = op_e'(opf);
    dec.known      = (opf <= 4'h6);
    dec.is_reg     = (opf >= 4'h1) && (opf <= 4'h5);
    dec.misaligned = dec.is_reg && (word[1:0] != 2'b00);
    dec.absolute   = word[27];
    dec.ofs        = word[OFS_W-1:0];
    dec.is_sel     = (opf == 4'h1) && word[27] && (word[OFS_W-1:0] == SEL_OFS);
  end

endmodule

// File: rtl/regcmd_blksel.sv
module regcmd_blksel
  import regcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] map
);

  logic [WORD_W-1:0] map_q, map_d;

  always_comb begin
    map_d = map_q;
    if (ld) map_d = din & SEL_VALID_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  assign map = map_q;

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(map_q));

  // R3
  sel_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> ((map_q & ~SEL_VALID_MASK) == '0));

endmodule

// File: rtl/regcmd_addr_gen.sv
module regcmd_addr_gen
  import regcmd_pkg::*;
#(
  parameter int unsigned AW = OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    start,
  input  logic             inc,
  input  logic             wrap_en,
  input  logic [WSZ_W-1:0] wrap_sz,
  input  logic             adv,
  output logic [AW-1:0]    cur
);

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0]    base_q, base_d, cur_q, cur_d;
  logic [WSZ_W-1:0] wcnt_q, wcnt_d, wsz_q, wsz_d;
  logic             inc_q, inc_d, wrap_q, wrap_d;
  logic             at_wrap;

  assign at_wrap = wrap_q && (wcnt_q == (wsz_q - WSZ_W'(1)));

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    wcnt_d = wcnt_q;
    wsz_d  = wsz_q;
    inc_d  = inc_q;
    wrap_d = wrap_q;
    if (load) begin
      base_d = start;
      cur_d  = start;
      wcnt_d = '0;
      wsz_d  = wrap_sz;
      inc_d  = inc;
      wrap_d = wrap_en;
    end else if (adv && inc_q) begin
      if (at_wrap) begin
        cur_d  = base_q;
        wcnt_d = '0;
      end else begin
        cur_d = cur_q + STEP;
        if (wrap_q) wcnt_d = wcnt_q + WSZ_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
      wcnt_q <= '0;
      wsz_q  <= '0;
      inc_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
      wcnt_q <= wcnt_d;
      wsz_q  <= wsz_d;
      inc_q  <= inc_d;
      wrap_q <= wrap_d;
    end
  end

  assign cur = cur_q;

  // R9
  wrap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && inc_q) |-> (wcnt_q < wsz_q));

  // R9
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && inc_q && at_wrap) |=> (cur_q == base_q));

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc_q) |=> $stable(cur_q));

endmodule

// File: rtl/regcmd_interp.sv
module regcmd_interp
  import regcmd_pkg::*;
#(
  parameter logic [OFS_W-1:0] SEL_OFS = 20'hAC060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [OFS_W-1:0]  bus_addr,
  output logic              bus_abs,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_rvalid,
  output logic [WORD_W-1:0] blk_sel,
  output logic              lut_wr,
  output logic              lut_table,
  output logic [15:0]       lut_block,
  output logic [7:0]        lut_xfer,
  output logic [WORD_W-1:0] lut_wdata,
  output logic              err
);

  localparam int unsigned PAD_W = $clog2(PAD_WORDS + 1);
  localparam logic [PAD_W-1:0] PAD_LAST = PAD_W'(PAD_WORDS - 1);

  hdr_t dec;
  logic take;

  state_e            state_q, state_d;
  op_e               op_q, op_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic              abs_q, abs_d;
  logic              selcmd_q, selcmd_d;
  logic              seen_q, seen_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] mask_q, mask_d, val_q, val_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAD_W-1:0]  pad_q, pad_d;
  logic              ltbl_q, ltbl_d;
  logic [15:0]       lblk_q, lblk_d;
  logic [7:0]        lxfer_q, lxfer_d;

  logic              bwr_q, bwr_d, brd_q, brd_d, babs_q, babs_d;
  logic [OFS_W-1:0]  baddr_q, baddr_d;
  logic [WORD_W-1:0] bwdata_q, bwdata_d;
  logic              lwr_q, lwr_d;
  logic [WORD_W-1:0] lwdata_q, lwdata_d;

  logic              sel_ld;
  logic              ag_load, ag_inc, ag_wrap, ag_adv;
  logic [OFS_W-1:0]  ag_cur;

  regcmd_hdr_decode #(.SEL_OFS(SEL_OFS)) u_dec (
    .word (cmd_data),
    .dec  (dec)
  );

  regcmd_blksel u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (sel_ld),
    .din   (cmd_data),
    .map   (blk_sel)
  );

  regcmd_addr_gen #(.AW(OFS_W)) u_ag (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ag_load),
    .start   (ofs_q),
    .inc     (ag_inc),
    .wrap_en (ag_wrap),
    .wrap_sz (cmd_data[19:16]),
    .adv     (ag_adv),
    .cur     (ag_cur)
  );

  assign cmd_ready = (state_q != ST_RD);
  assign take      = cmd_valid && cmd_ready;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    ofs_d    = ofs_q;
    abs_d    = abs_q;
    selcmd_d = selcmd_q;
    seen_d   = seen_q;
    err_d    = err_q;
    mask_d   = mask_q;
    val_d    = val_q;
    cnt_d    = cnt_q;
    pad_d    = pad_q;
    ltbl_d   = ltbl_q;
    lblk_d   = lblk_q;
    lxfer_d  = lxfer_q;
    bwr_d    = 1'b0;
    brd_d    = 1'b0;
    lwr_d    = 1'b0;
    baddr_d  = baddr_q;
    babs_d   = babs_q;
    bwdata_d = bwdata_q;
    lwdata_d = lwdata_q;
    sel_ld   = 1'b0;
    ag_load  = 1'b0;
    ag_inc   = 1'b0;
    ag_wrap  = 1'b0;
    ag_adv   = 1'b0;

    unique case (state_q)
      ST_HDR: if (take) begin
        if (!dec.known || dec.misaligned) begin
          state_d = ST_ERR;
          err_d   = 1'b1;
        end else if (dec.op == OP_NOP) begin
          state_d = ST_HDR;
        end else if (!dec.is_sel && !seen_q) begin
          state_d = ST_ERR;
          err_d   = 1'b1;
        end else begin
          op_d     = dec.op;
          ofs_d    = dec.ofs;
          abs_d    = dec.absolute;
          selcmd_d = dec.is_sel;
          ltbl_d   = cmd_data[16];
          lblk_d   = cmd_data[15:0];
          state_d  = ST_ARG;
        end
      end

      ST_ARG: if (take) begin
        unique case (op_q)
          OP_SINGLE: begin
            if (selcmd_q) begin
              sel_ld = 1'b1;
              seen_d = 1'b1;
            end else begin
              bwr_d    = 1'b1;
              baddr_d  = ofs_q;
              babs_d   = abs_q;
              bwdata_d = cmd_data;
            end
            state_d = ST_HDR;
          end
          OP_MODIFY: begin
            mask_d  = cmd_data;
            state_d = ST_VAL;
          end
          OP_INDEX, OP_AUTOINC, OP_WRAP: begin
            if ((op_q == OP_WRAP) && (cmd_data[19:16] < WRAP_MIN)) begin
              state_d = ST_ERR;
              err_d   = 1'b1;
            end else begin
              ag_load = 1'b1;
              ag_inc  = (op_q == OP_AUTOINC) || ((op_q == OP_WRAP) && !cmd_data[31]);
              ag_wrap = (op_q == OP_WRAP);
              cnt_d   = cmd_data[CNT_W-1:0];
              state_d = (cmd_data[CNT_W-1:0] == '0) ? ST_HDR : ST_DATA;
            end
          end
          OP_LUT: begin
            lxfer_d = cmd_data[23:16];
            cnt_d   = cmd_data[CNT_W-1:0];
            pad_d   = '0;
            state_d = (cmd_data[CNT_W-1:0] == '0) ? ST_PAD : ST_LUT;
          end
          default: begin
            state_d = ST_ERR;
            err_d   = 1'b1;
          end
        endcase
      end

      ST_VAL: if (take) begin
        val_d   = cmd_data;
        brd_d   = 1'b1;
        baddr_d = ofs_q;
        babs_d  = abs_q;
        state_d = ST_RD;
      end

      ST_RD: if (bus_rvalid) begin
        bwr_d    = 1'b1;
        bwdata_d = (bus_rdata & ~mask_q) | (val_q & mask_q);
        state_d  = ST_HDR;
      end

      ST_DATA: if (take) begin
        bwr_d    = 1'b1;
        baddr_d  = ag_cur;
        babs_d   = abs_q;
        bwdata_d = cmd_data;
        ag_adv   = 1'b1;
        cnt_d    = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) state_d = ST_HDR;
      end

      ST_LUT: if (take) begin
        lwr_d    = 1'b1;
        lwdata_d = cmd_data;
        cnt_d    = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          pad_d   = '0;
          state_d = ST_PAD;
        end
      end

      ST_PAD: if (take) begin
        if (cmd_data[31:28] != 4'h0) begin
          state_d = ST_ERR;
          err_d   = 1'b1;
        end else begin
          pad_d = pad_q + PAD_W'(1);
          if (pad_q == PAD_LAST) state_d = ST_HDR;
        end
      end

      ST_ERR: state_d = ST_ERR;

      default: begin
        state_d = ST_ERR;
        err_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HDR;
      op_q     <= OP_NOP;
      ofs_q    <= '0;
      abs_q    <= 1'b0;
      selcmd_q <= 1'b0;
      seen_q   <= 1'b0;
      err_q    <= 1'b0;
      mask_q   <= '0;
      val_q    <= '0;
      cnt_q    <= '0;
      pad_q    <= '0;
      ltbl_q   <= 1'b0;
      lblk_q   <= '0;
      lxfer_q  <= '0;
      bwr_q    <= 1'b0;
      brd_q    <= 1'b0;
      baddr_q  <= '0;
      babs_q   <= 1'b0;
      bwdata_q <= '0;
      lwr_q    <= 1'b0;
      lwdata_q <= '0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      ofs_q    <= ofs_d;
      abs_q    <= abs_d;
      selcmd_q <= selcmd_d;
      seen_q   <= seen_d;
      err_q    <= err_d;
      mask_q   <= mask_d;
      val_q    <= val_d;
      cnt_q    <= cnt_d;
      pad_q    <= pad_d;
      ltbl_q   <= ltbl_d;
      lblk_q   <= lblk_d;
      lxfer_q  <= lxfer_d;
      bwr_q    <= bwr_d;
      brd_q    <= brd_d;
      baddr_q  <= baddr_d;
      babs_q   <= babs_d;
      bwdata_q <= bwdata_d;
      lwr_q    <= lwr_d;
      lwdata_q <= lwdata_d;
    end
  end

  assign bus_wr    = bwr_q;
  assign bus_rd    = brd_q;
  assign bus_addr  = baddr_q;
  assign bus_abs   = babs_q;
  assign bus_wdata = bwdata_q;
  assign lut_wr    = lwr_q;
  assign lut_table = ltbl_q;
  assign lut_block = lblk_q;
  assign lut_xfer  = lxfer_q;
  assign lut_wdata = lwdata_q;
  assign err       = err_q;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr, bus_rd, lut_wr}));

  // R6
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !cmd_ready);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R12
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!bus_wr && !bus_rd && !lut_wr));

  // R4
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |=> !bus_wr);

  // R5
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_addr[1:0] == 2'b00));

endmodule

// File: tb/sim_regcmd_interp.sv
module sim_regcmd_interp;

  logic        clk, rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready;
  logic        bus_wr, bus_rd, bus_abs, bus_rvalid;
  logic [19:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, blk_sel, lut_wdata;
  logic        lut_wr, lut_table, err;
  logic [15:0] lut_block;
  logic [7:0]  lut_xfer;

  int checks = 0;
  int errors = 0;

  regcmd_interp u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_abs(bus_abs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .blk_sel(blk_sel), .lut_wr(lut_wr),
    .lut_table(lut_table), .lut_block(lut_block), .lut_xfer(lut_xfer),
    .lut_wdata(lut_wdata), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {header, value, expected address, expected absolute flag}
  localparam logic [84:0] VEC [0:3] = '{
    {32'h1000_0010, 32'hDEAD_BEEF, 20'h00010, 1'b0},
    {32'h1800_0100, 32'h0000_1234, 20'h00100, 1'b1},
    {32'h100F_FFFC, 32'h0000_0005, 20'hFFFFC, 1'b0},
    {32'h1000_0000, 32'h0000_0000, 20'h00000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    cmd_valid = 1'b1;
    cmd_data  = w;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic select(input logic [31:0] map);
    push(32'h180A_C060);
    push(map);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0;
    bus_rvalid = 1'b0; bus_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 ready", 32'(cmd_ready), 32'd1);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 strobes", 32'({bus_wr, bus_rd, lut_wr}), 32'd0);
    chk("R1 blk_sel", blk_sel, 32'd0);

    // R2 no-op
    push(32'h0123_4567);
    chk("R2 no write", 32'({bus_wr, lut_wr}), 32'd0);
    chk("R2 no err", 32'(err), 32'd0);

    // R3 select with masking
    select(32'hFFFF_FFFF);
    chk("R3 map", blk_sel, 32'h80FE_01FF);
    chk("R3 no bus write", 32'(bus_wr), 32'd0);

    // R5 single writes from vector table
    for (int i = 0; i < 4; i++) begin
      push(VEC[i][84:53]);
      chk("R5 hdr idle", 32'(bus_wr), 32'd0);
      push(VEC[i][52:21]);
      chk("R5 wr", 32'(bus_wr), 32'd1);
      chk("R5 addr", 32'(bus_addr), 32'(VEC[i][20:1]));
      chk("R5 abs", 32'(bus_abs), 32'(VEC[i][0]));
      chk("R5 data", bus_wdata, VEC[i][52:21]);
    end

    select(32'h0000_0003);
    chk("R3 reload", blk_sel, 32'h0000_0003);

    // R6 masked modify
    push(32'h2000_0040);
    push(32'h0000_FF00);
    push(32'h1234_5678);
    chk("R6 rd", 32'(bus_rd), 32'd1);
    chk("R6 rd addr", 32'(bus_addr), 32'h40);
    chk("R6 stall", 32'(cmd_ready), 32'd0);
    bus_rvalid = 1'b1; bus_rdata = 32'hAAAA_AAAA;
    @(posedge clk); #1;
    bus_rvalid = 1'b0;
    chk("R6 wr", 32'(bus_wr), 32'd1);
    chk("R6 merged", bus_wdata, 32'hAAAA_56AA);
    chk("R6 addr", 32'(bus_addr), 32'h40);

    // R7 indexed block
    push(32'h3000_0080);
    push(32'd3);
    for (int i = 0; i < 3; i++) begin
      push(32'(i + 1));
      chk("R7 wr", 32'(bus_wr), 32'd1);
      chk("R7 addr", 32'(bus_addr), 32'h80);
      chk("R7 data", bus_wdata, 32'(i + 1));
    end

    // R8 auto increment
    push(32'h4000_0200);
    push(32'd4);
    for (int i = 0; i < 4; i++) begin
      push(32'h100 + 32'(i));
      chk("R8 addr", 32'(bus_addr), 32'h200 + 32'(4 * i));
    end

    // R9 wrapping, size 3, count 7
    push(32'h5000_0300);
    push(32'h0003_0007);
    for (int i = 0; i < 7; i++) begin
      push(32'(i));
      chk("R9 wrap addr", 32'(bus_addr), 32'h300 + 32'(4 * (i % 3)));
    end
    // R9 non-incrementing
    push(32'h5000_0300);
    push(32'h8002_0002);
    for (int i = 0; i < 2; i++) begin
      push(32'(i));
      chk("R9 hold addr", 32'(bus_addr), 32'h300);
    end

    // R13 zero count
    push(32'h4000_0400);
    push(32'h0000_0000);
    chk("R13 no wr", 32'(bus_wr), 32'd0);
    push(32'h1000_0020);
    chk("R13 next hdr", 32'(bus_wr), 32'd0);
    push(32'h0000_0077);
    chk("R13 then write", 32'(bus_addr), 32'h20);
    chk("R13 err", 32'(err), 32'd0);

    // R10 table write, R11 padding
    push(32'h6001_0025);
    push(32'h0040_0002);
    push(32'h0000_000A);
    chk("R10 lut_wr", 32'(lut_wr), 32'd1);
    chk("R10 table", 32'(lut_table), 32'd1);
    chk("R10 block", 32'(lut_block), 32'h25);
    chk("R10 xfer", 32'(lut_xfer), 32'h40);
    chk("R10 data", lut_wdata, 32'hA);
    push(32'h0000_000B);
    chk("R10 data2", lut_wdata, 32'hB);
    for (int i = 0; i < 3; i++) push(32'h0);
    chk("R11 pad ok", 32'(err), 32'd0);
    push(32'h1000_0030);
    push(32'h0000_0009);
    chk("R11 after pad", 32'(bus_addr), 32'h30);

    // R11 bad pad, then R12 discard
    push(32'h6000_0001);
    push(32'h0040_0001);
    push(32'h0000_0001);
    push(32'h1000_0010);
    chk("R11 bad pad", 32'(err), 32'd1);
    push(32'h1000_0010);
    push(32'h0000_0055);
    chk("R12 discard", 32'(bus_wr), 32'd0);
    chk("R12 sticky", 32'(err), 32'd1);
    chk("R12 ready", 32'(cmd_ready), 32'd1);

    // R4 write before select
    do_reset();
    push(32'h1000_0010);
    push(32'h0000_0001);
    chk("R4 err", 32'(err), 32'd1);
    chk("R4 no wr", 32'(bus_wr), 32'd0);

    // R12 undefined opcode
    do_reset();
    select(32'h1);
    push(32'h7000_0000);
    chk("R12 bad opcode", 32'(err), 32'd1);

    // R12 misaligned offset
    do_reset();
    select(32'h1);
    push(32'h1000_0012);
    chk("R12 misaligned", 32'(err), 32'd1);

    // R9 illegal wrap size
    do_reset();
    select(32'h1);
    push(32'h5000_0000);
    push(32'h0001_0004);
    chk("R9 wrap size", 32'(err), 32'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule